// File: doc/BRIEF.md
# Pending Interrupt Request Dispatcher

This block sits behind the masking logic of a processor's interrupt front end. Each time it is invoked it looks at a vector of eligible pending requests from seven sources. It picks exactly one request by fixed priority and carries out that source's service sequence. Where a source needs it, the sequence asks the hypervisor for an intercept check with an exit code. For an external interrupt it also fetches the vector from the interrupt controller through a request/acknowledge handshake.

When servicing ends, the block emits a one-cycle completion strobe together with a set of one-cycle action strobes. These tell the surrounding logic which pending bits to clear, whether to raise the NMI-blocked flag, and whether to drop the virtual-IRQ control bit. They also say which command to issue: APIC poll, startup IPI handling, SMM entry, or event delivery with a vector and a hardware-interrupt flag. An intercept that reports an exit aborts servicing, and nothing is cleared or issued.

Pending bit order: bit0 APIC poll, bit1 startup IPI, bit2 SMI, bit3 NMI, bit4 machine check, bit5 external interrupt, bit6 virtual interrupt.

Top module: `irq_dispatch`

## Requirements
- R1: An invocation (`start` high while idle) with `pend` all zero yields `done` one cycle later with `serviced`=0, `aborted`=0, `clr_mask`=0 and no command or delivery strobe.
- R2: When several bits of `pend` are set, only the lowest-numbered one is serviced, so the priority is bit0 highest down to bit6 lowest.
- R3: A poll request (bit0) completes one cycle after `start` with `clr_mask`=7'h01 and `poll_cmd`. A startup IPI (bit1) completes one cycle after `start` with `sipi_cmd` and `clr_mask`=0. Neither requests an intercept check.
- R4: An SMI (bit2) first raises `icpt_req` with `icpt_code`=12'h062. After a non-exit `icpt_done` it completes with `clr_mask`=7'h04 and `smm_cmd`.
- R5: An NMI (bit3) raises `icpt_req` with code 12'h061. It then completes with `clr_mask`=7'h08, `nmi_blk_set`, and a delivery of vector 2 with `dlv_hw`=1.
- R6: A machine check (bit4) completes one cycle after `start` without an intercept. It gives `clr_mask`=7'h10 and delivers vector 18 with `dlv_hw`=0.
- R7: An external interrupt (bit5) raises `icpt_req` with code 12'h060. After the check passes, it raises `ack_req` and waits for `ack_done`. It then completes with `clr_mask`=7'h60 and a delivery of the acknowledged vector with `dlv_hw`=1.
- R8: A virtual interrupt (bit6) raises `icpt_req` with code 12'h064. It then completes with `clr_mask`=7'h40, `virq_ctl_clr`, and a delivery of `virt_vector` with `dlv_hw`=1.
- R9: `icpt_done` with `icpt_exit`=1 ends the invocation one cycle later with `aborted`=1 and `serviced`=0. It clears nothing, issues no command, and raises no `ack_req`.
- R10: `icpt_req` and `ack_req` stay high until their respective done input arrives, and they are never high together. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Invoke servicing (honoured while idle) |
| pend | input | 7 | Eligible pending requests |
| icpt_req | output | 1 | Intercept check request, held until answered |
| icpt_code | output | 12 | Exit code for the intercept check |
| icpt_done | input | 1 | Intercept check answered |
| icpt_exit | input | 1 | Intercept check answer: exit taken |
| ack_req | output | 1 | Interrupt controller acknowledge request |
| ack_done | input | 1 | Acknowledge returned |
| ack_vector | input | 8 | Vector returned with the acknowledge |
| virt_vector | input | 8 | Virtual interrupt vector from the control block |
| done | output | 1 | Invocation finished (pulse) |
| serviced | output | 1 | A request was serviced |
| aborted | output | 1 | Servicing aborted by an intercept exit |
| clr_mask | output | 7 | Pending bits to clear |
| nmi_blk_set | output | 1 | Set the NMI-blocked flag |
| virq_ctl_clr | output | 1 | Clear the virtual-IRQ control bit |
| poll_cmd | output | 1 | Issue APIC poll |
| sipi_cmd | output | 1 | Issue startup IPI handling |
| smm_cmd | output | 1 | Issue SMM entry |
| dlv_valid | output | 1 | Deliver an event |
| dlv_vector | output | 8 | Delivered vector |
| dlv_hw | output | 1 | Delivered event is a hardware interrupt |

## Verification
The assertions assume that `start` is asserted only while neither handshake request is outstanding. They also assume that `icpt_done` and `ack_done` arrive only while the matching request is high, and that `virt_vector` is steady across the cycle in which the intercept answer is taken. The stimulus keeps within these assumptions in three ways. It starts each invocation only after the previous `done` pulse. It raises each done input for one cycle, and only after it has seen the corresponding request. It changes `virt_vector` only between invocations.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int NSRC = 7;
  localparam int B_POLL = 0;
  localparam int B_SIPI = 1;
  localparam int B_SMI  = 2;
  localparam int B_NMI  = 3;
  localparam int B_MCE  = 4;
  localparam int B_EXT  = 5;
  localparam int B_VIRT = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_ICPT, ST_ACK} st_t;
  typedef enum logic [1:0] {VS_NMI, VS_MCE, VS_ACK, VS_VIRT} vsel_t;

  typedef struct packed {
    logic            need_icpt;
    logic            need_ack;
    logic [NSRC-1:0] clr;
    logic            nmi_set;
    logic            virq_clr;
    logic            poll;
    logic            sipi;
    logic            smm;
    logic            dlv;
    logic            hw;
    vsel_t           vsel;
  } act_t;
endpackage

// File: rtl/irqd_prio.sv
module irqd_prio #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_pick
    assign seen[i+1] = seen[i] | req[i];
    assign grant[i]  = req[i] & ~seen[i];
  end
endmodule

// File: rtl/irqd_decode.sv
module irqd_decode
  import irqd_pkg::*;
#(
  parameter int          CODE_W    = 12,
  parameter logic [11:0] CODE_SMI  = 12'h062,
  parameter logic [11:0] CODE_NMI  = 12'h061,
  parameter logic [11:0] CODE_INTR = 12'h060,
  parameter logic [11:0] CODE_VINT = 12'h064
) (
  input  logic [NSRC-1:0]   grant,
  output act_t              act,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    act  = '0;
    code = '0;
    act.vsel = VS_NMI;
    if (grant[B_POLL]) begin
      act.clr[B_POLL] = 1'b1;
      act.poll        = 1'b1;
    end else if (grant[B_SIPI]) begin
      act.sipi = 1'b1;
    end else if (grant[B_SMI]) begin
      act.need_icpt  = 1'b1;
      code           = CODE_W'(CODE_SMI);
      act.clr[B_SMI] = 1'b1;
      act.smm        = 1'b1;
    end else if (grant[B_NMI]) begin
      act.need_icpt  = 1'b1;
      code           = CODE_W'(CODE_NMI);
      act.clr[B_NMI] = 1'b1;
      act.nmi_set    = 1'b1;
      act.dlv        = 1'b1;
      act.hw         = 1'b1;
      act.vsel       = VS_NMI;
    end else if (grant[B_MCE]) begin
      act.clr[B_MCE] = 1'b1;
      act.dlv        = 1'b1;
      act.vsel       = VS_MCE;
    end else if (grant[B_EXT]) begin
      act.need_icpt   = 1'b1;
      act.need_ack    = 1'b1;
      code            = CODE_W'(CODE_INTR);
      act.clr[B_EXT]  = 1'b1;
      act.clr[B_VIRT] = 1'b1;
      act.dlv         = 1'b1;
      act.hw          = 1'b1;
      act.vsel        = VS_ACK;
    end else if (grant[B_VIRT]) begin
      act.need_icpt   = 1'b1;
      code            = CODE_W'(CODE_VINT);
      act.clr[B_VIRT] = 1'b1;
      act.virq_clr    = 1'b1;
      act.dlv         = 1'b1;
      act.hw          = 1'b1;
      act.vsel        = VS_VIRT;
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irqd_pkg::*;
#(
  parameter int          VEC_W     = 8,
  parameter int          CODE_W    = 12,
  parameter logic [11:0] CODE_SMI  = 12'h062,
  parameter logic [11:0] CODE_NMI  = 12'h061,
  parameter logic [11:0] CODE_INTR = 12'h060,
  parameter logic [11:0] CODE_VINT = 12'h064,
  parameter int          NMI_VEC   = 2,
  parameter int          MCE_VEC   = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [6:0]        pend,
  output logic              icpt_req,
  output logic [CODE_W-1:0] icpt_code,
  input  logic              icpt_done,
  input  logic              icpt_exit,
  output logic              ack_req,
  input  logic              ack_done,
  input  logic [VEC_W-1:0]  ack_vector,
  input  logic [VEC_W-1:0]  virt_vector,
  output logic              done,
  output logic              serviced,
  output logic              aborted,
  output logic [6:0]        clr_mask,
  output logic              nmi_blk_set,
  output logic              virq_ctl_clr,
  output logic              poll_cmd,
  output logic              sipi_cmd,
  output logic              smm_cmd,
  output logic              dlv_valid,
  output logic [VEC_W-1:0]  dlv_vector,
  output logic              dlv_hw
);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);
  localparam logic [VEC_W-1:0] MCE_V = VEC_W'(MCE_VEC);

  logic [NSRC-1:0]   grant;
  act_t              act_d, act_q, fin_act;
  logic [CODE_W-1:0] code_d;
  st_t               st_q, st_d;
  logic              fin, fin_none, fin_abort;
  logic [VEC_W-1:0]  fin_vec;

  irqd_prio #(.N(NSRC)) u_prio (.req(pend), .grant(grant));

  irqd_decode #(
    .CODE_W(CODE_W), .CODE_SMI(CODE_SMI), .CODE_NMI(CODE_NMI),
    .CODE_INTR(CODE_INTR), .CODE_VINT(CODE_VINT)
  ) u_dec (.grant(grant), .act(act_d), .code(code_d));

  always_comb begin
    st_d      = st_q;
    fin       = 1'b0;
    fin_none  = 1'b0;
    fin_abort = 1'b0;
    fin_act   = act_q;
    case (st_q)
      ST_IDLE: begin
        fin_act = act_d;
        if (start) begin
          if (pend == '0) begin
            fin      = 1'b1;
            fin_none = 1'b1;
          end else if (act_d.need_icpt) begin
            st_d = ST_ICPT;
          end else begin
            fin = 1'b1;
          end
        end
      end
      ST_ICPT: begin
        if (icpt_done) begin
          if (icpt_exit) begin
            fin       = 1'b1;
            fin_abort = 1'b1;
            st_d      = ST_IDLE;
          end else if (act_q.need_ack) begin
            st_d = ST_ACK;
          end else begin
            fin  = 1'b1;
            st_d = ST_IDLE;
          end
        end
      end
      ST_ACK: begin
        if (ack_done) begin
          fin  = 1'b1;
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    case (fin_act.vsel)
      VS_NMI:  fin_vec = NMI_V;
      VS_MCE:  fin_vec = MCE_V;
      VS_ACK:  fin_vec = ack_vector;
      default: fin_vec = virt_vector;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      act_q     <= '0;
      icpt_code <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start) begin
        act_q     <= act_d;
        icpt_code <= code_d;
      end
    end
  end

  assign icpt_req = (st_q == ST_ICPT);
  assign ack_req  = (st_q == ST_ACK);

  logic go;
  assign go = fin & ~fin_none & ~fin_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      serviced     <= 1'b0;
      aborted      <= 1'b0;
      clr_mask     <= '0;
      nmi_blk_set  <= 1'b0;
      virq_ctl_clr <= 1'b0;
      poll_cmd     <= 1'b0;
      sipi_cmd     <= 1'b0;
      smm_cmd      <= 1'b0;
      dlv_valid    <= 1'b0;
      dlv_vector   <= '0;
      dlv_hw       <= 1'b0;
    end else begin
      done         <= fin;
      serviced     <= go;
      aborted      <= fin & fin_abort;
      clr_mask     <= go ? fin_act.clr : '0;
      nmi_blk_set  <= go & fin_act.nmi_set;
      virq_ctl_clr <= go & fin_act.virq_clr;
      poll_cmd     <= go & fin_act.poll;
      sipi_cmd     <= go & fin_act.sipi;
      smm_cmd      <= go & fin_act.smm;
      dlv_valid    <= go & fin_act.dlv;
      dlv_vector   <= (go & fin_act.dlv) ? fin_vec : '0;
      dlv_hw       <= go & fin_act.dlv & fin_act.hw;
    end
  end

  // R1
  empty_call_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !icpt_req && !ack_req && pend == '0) |=>
      (done && !serviced && clr_mask == '0 && !dlv_valid));

  // R2
  single_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({poll_cmd, sipi_cmd, smm_cmd, dlv_valid}));

  // R5
  nmi_vec_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_blk_set |-> (dlv_valid && dlv_hw && dlv_vector == NMI_V));

  // R7
  ack_deliver_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_req && ack_done) |=>
      (done && dlv_valid && dlv_hw && dlv_vector == $past(ack_vector)));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (icpt_req && icpt_done && icpt_exit) |=>
      (done && aborted && !serviced && clr_mask == '0 && !ack_req));

  // R10
  hs_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(icpt_req && ack_req));

  // R10
  icpt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (icpt_req && !icpt_done) |=> (icpt_req && $stable(icpt_code)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/irq_dispatch_test.sv
module irq_dispatch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [6:0]  pend = '0;
  logic        icpt_done = 1'b0, icpt_exit = 1'b0;
  logic        ack_done = 1'b0;
  logic [7:0]  ack_vector = '0, virt_vector = '0;
  logic        icpt_req, ack_req, done, serviced, aborted;
  logic [11:0] icpt_code;
  logic [6:0]  clr_mask;
  logic        nmi_blk_set, virq_ctl_clr, poll_cmd, sipi_cmd, smm_cmd;
  logic        dlv_valid, dlv_hw;
  logic [7:0]  dlv_vector;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch uut (
    .clk(clk), .rst(rst), .start(start), .pend(pend),
    .icpt_req(icpt_req), .icpt_code(icpt_code), .icpt_done(icpt_done),
    .icpt_exit(icpt_exit), .ack_req(ack_req), .ack_done(ack_done),
    .ack_vector(ack_vector), .virt_vector(virt_vector), .done(done),
    .serviced(serviced), .aborted(aborted), .clr_mask(clr_mask),
    .nmi_blk_set(nmi_blk_set), .virq_ctl_clr(virq_ctl_clr),
    .poll_cmd(poll_cmd), .sipi_cmd(sipi_cmd), .smm_cmd(smm_cmd),
    .dlv_valid(dlv_valid), .dlv_vector(dlv_vector), .dlv_hw(dlv_hw)
  );

  function automatic logic [31:0] outs();
    return {8'h0, done, serviced, aborted, clr_mask, nmi_blk_set, virq_ctl_clr,
            poll_cmd, sipi_cmd, smm_cmd, dlv_valid, dlv_hw, dlv_vector};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      summary();
      $finish;
    end
  end

  // Behavioural model of one invocation, compared cycle by cycle.
  task automatic invoke(input logic [6:0] req, input int idly, input bit ex,
                        input int adly, input logic [7:0] av, input string tag);
    int w = -1;
    bit need_i = 0, need_a = 0;
    logic [11:0] code = '0;
    bit sv, ab, nmi = 0, vq = 0, pl = 0, sp = 0, sm = 0, dv = 0, hw = 0;
    logic [6:0] clr = '0;
    logic [7:0] vec = '0;
    logic [31:0] exp;
    for (int i = 0; i < 7; i++) if (req[i] && w < 0) w = i;
    case (w)
      0: begin clr = 7'h01; pl = 1; end
      1: sp = 1;
      2: begin need_i = 1; code = 12'h062; clr = 7'h04; sm = 1; end
      3: begin need_i = 1; code = 12'h061; clr = 7'h08; nmi = 1; dv = 1; hw = 1; vec = 8'd2; end
      4: begin clr = 7'h10; dv = 1; vec = 8'd18; end
      5: begin need_i = 1; need_a = 1; code = 12'h060; clr = 7'h60; dv = 1; hw = 1; vec = av; end
      6: begin need_i = 1; code = 12'h064; clr = 7'h40; vq = 1; dv = 1; hw = 1; vec = virt_vector; end
      default: ;
    endcase
    ab = need_i && ex;
    sv = (w >= 0) && !ab;
    if (!sv) begin
      clr = '0; nmi = 0; vq = 0; pl = 0; sp = 0; sm = 0; dv = 0; hw = 0; vec = '0;
    end
    exp = {8'h0, 1'b1, sv, ab, clr, nmi, vq, pl, sp, sm, dv, hw, vec};

    @(negedge clk); pend = req; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (need_i) begin
      chk(icpt_req && !ack_req && !done && icpt_code == code, {tag, " icpt"},
          {19'h0, icpt_req, icpt_code}, {19'h0, 1'b1, code});
      for (int k = 0; k < idly; k++) begin
        @(negedge clk);
        chk(icpt_req && !done, "R10 icpt hold", {31'h0, icpt_req}, 32'h1);
      end
      icpt_done = 1'b1; icpt_exit = ex;
      @(negedge clk); icpt_done = 1'b0; icpt_exit = 1'b0;
      if (need_a && !ex) begin
        chk(ack_req && !icpt_req && !done, "R7 ack_req", {30'h0, ack_req, icpt_req}, 32'h2);
        for (int k = 0; k < adly; k++) begin
          @(negedge clk);
          chk(ack_req && !done, "R10 ack hold", {31'h0, ack_req}, 32'h1);
        end
        ack_done = 1'b1; ack_vector = av;
        @(negedge clk); ack_done = 1'b0; ack_vector = '0;
      end
    end
    chk(outs() == exp, tag, outs(), exp);
    @(negedge clk);
    chk(!done && !icpt_req && !ack_req, "R10 done pulse", outs(), 32'h0);
    pend = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(outs() == 32'h0 && !icpt_req && !ack_req, "R10 reset", outs(), 32'h0);

    invoke(7'h00, 0, 0, 0, 8'h00, "R1 empty");
    invoke(7'h01, 0, 0, 0, 8'h00, "R3 poll");
    invoke(7'h02, 0, 0, 0, 8'h00, "R3 sipi");
    invoke(7'h04, 2, 0, 0, 8'h00, "R4 smi");
    invoke(7'h08, 0, 0, 0, 8'h00, "R5 nmi");
    invoke(7'h10, 0, 0, 0, 8'h00, "R6 mce");
    invoke(7'h20, 1, 0, 3, 8'h41, "R7 ext");
    invoke(7'h20, 0, 0, 0, 8'hF0, "R7 ext fast");
    virt_vector = 8'h77;
    invoke(7'h40, 2, 0, 0, 8'h00, "R8 virt");
    virt_vector = 8'hA5;
    invoke(7'h40, 0, 0, 0, 8'h00, "R8 virt2");
    invoke(7'h7F, 0, 0, 0, 8'h00, "R2 all pending");
    invoke(7'h7C, 1, 0, 0, 8'h00, "R2 smi over rest");
    invoke(7'h70, 0, 0, 0, 8'h00, "R2 mce over ext");
    invoke(7'h60, 1, 0, 2, 8'h33, "R2 ext over virt");
    invoke(7'h48, 0, 0, 0, 8'h00, "R2 nmi over virt");
    invoke(7'h04, 1, 1, 0, 8'h00, "R9 smi exit");
    invoke(7'h20, 2, 1, 0, 8'h00, "R9 ext exit");
    invoke(7'h08, 0, 1, 0, 8'h00, "R9 nmi exit");
    invoke(7'h02, 0, 0, 0, 8'h00, "R3 sipi after abort");

    summary();
    $finish;
  end
endmodule